// File: doc/BRIEF.md
# UART Bit-Period Transmit Generator

This block turns bytes into a serial UART frame on a single transmit line. Each frame has a low start bit, eight data bits sent least significant bit first, and a high stop bit. Between frames the line stays high. The length of every bit is set by a plain down counter that runs on the sample clock, so the line only changes on a sample-clock edge. No mid-bit timing or resynchronization is involved.

The bit period reuses the receive-side divider and adds a transmit offset of zero or one. The offset exists because the receive divider is sometimes trimmed one below nominal to place receive sampling better, and the transmitter can add that cycle back. A ten-bit correction mask fine-tunes the baud rate. Each mask bit belongs to one frame bit and makes that bit one sample clock longer.

A byte is accepted through a valid/ready handshake. The divider, offset and mask are captured together with the byte. A controller sees the line and a busy flag.

The control machine has four states:
- `ST_IDLE`: the line is high and ready is asserted.
- `ST_START`: the start bit is being sent.
- `ST_DATA`: the eight data bits are being sent.
- `ST_STOP`: the stop bit is being sent.

Its transitions are:
- ACCEPT: `ST_IDLE` to `ST_START` on valid and ready.
- START_DONE: `ST_START` to `ST_DATA` when the start bit's count expires.
- NEXT_DATA: `ST_DATA` to `ST_DATA` at the end of data bits 0 to 6.
- DATA_DONE: `ST_DATA` to `ST_STOP` at the end of data bit 7.
- STOP_DONE: `ST_STOP` to `ST_IDLE` when the stop bit's count expires.

Top module: `uart_tx_gen`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A frame consists of frame bits 0 to 9. Bit 0 is the start bit at level 0. Bits 1 to 8 are data bits 0 to 7, least significant bit first. Bit 9 is the stop bit at level 1.
- R3: With a correction mask bit clear, the matching frame bit lasts `rx_div + tx_offset` clock cycles, counted with the zero rule of R5 applied to `rx_div`.
- R4: Setting `corr_mask[i]` makes frame bit i (bit 0 the start bit, bit 9 the stop bit) last exactly one clock cycle longer.
- R5: An `rx_div` of 0 is used as 1, so the smallest bit period is one cycle.
- R6: `in_ready` is 1 only in `ST_IDLE`. A byte is taken on a clock edge where `in_valid` and `in_ready` are both 1. `tx_line` goes to 0 and `busy` goes to 1 on that same edge, and `busy` stays 1 until the stop bit ends.
- R7: When the stop bit ends, the block is idle for exactly one cycle with `in_ready` at 1. A byte held valid in that cycle starts its start bit on the next edge.
- R8: `rx_div`, `tx_offset`, `corr_mask` and `in_data` are captured when the byte is accepted. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte (idle) |
| rx_div | input | DIV_W (12) | Receive-side divider, in sample clocks |
| tx_offset | input | 1 | Transmit offset of 0 or 1 added to the divider |
| corr_mask | input | 10 | Per-frame-bit lengthening mask, bit 0 is the start bit |
| tx_line | output | 1 | Serial transmit line, idles high |
| busy | output | 1 | A frame is in progress |

## Verification
The assertions assume that the upstream side follows the handshake: a byte offered while `in_ready` is 0 is simply held and not counted as accepted. They also assume that `in_valid` and the configuration inputs are stable around the clock edge.

The bench changes every input only at the falling edge. It offers a byte only when the block is idle or in the single idle cycle after a stop bit. It scrambles the divider, offset, mask and data right after acceptance so that the capture rule is exercised.

Random dividers are kept small, from 0 to 7, so that many full frames fit in the run. This range still covers the zero and one-cycle boundaries.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 2;   // start + data + stop

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_e;
endpackage

// File: rtl/uart_tx_period.sv
// Combinational bit-period calculator: yields period minus one.
module uart_tx_period #(
    parameter int DIV_W = 12
) (
    input  logic [DIV_W-1:0] div,
    input  logic             offset,
    input  logic             stretch,
    output logic [DIV_W:0]   period_m1
);
    logic [DIV_W:0] eff_div;

    always_comb begin
        // A zero divider would stall the counter; use one instead.
        eff_div   = (div == '0) ? (DIV_W+1)'(1) : {1'b0, div};
        period_m1 = eff_div + {{DIV_W{1'b0}}, offset}
                            + {{DIV_W{1'b0}}, stretch}
                            - (DIV_W+1)'(1);
    end
endmodule

// File: rtl/uart_tx_counter.sv
// Loadable down counter; expired is high while the count sits at zero.
module uart_tx_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/uart_tx_gen.sv
module uart_tx_gen
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_BITS-1:0]  in_data,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [DIV_W-1:0]      rx_div,
    input  logic                  tx_offset,
    input  logic [FRAME_BITS-1:0] corr_mask,
    output logic                  tx_line,
    output logic                  busy
);
    localparam int IDX_W  = $clog2(FRAME_BITS);
    localparam int DSEL_W = $clog2(DATA_BITS);
    localparam int CNT_W  = DIV_W + 1;

    tx_state_e             state, nxt_state;
    logic [IDX_W-1:0]      idx_q, idx_d;
    logic [DATA_BITS-1:0]  data_q;
    logic [DIV_W-1:0]      div_q;
    logic                  off_q;
    logic [FRAME_BITS-1:0] mask_q;

    logic                  accept;
    logic                  expired;
    logic                  bit_end;
    logic                  load;
    logic [DIV_W-1:0]      sel_div;
    logic                  sel_off;
    logic [FRAME_BITS-1:0] sel_mask;
    logic                  stretch;
    logic [CNT_W-1:0]      period_m1;
    logic [IDX_W-1:0]      dpos;
    logic                  line_d;

    assign in_ready = (state == ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign bit_end  = (state != ST_IDLE) && expired;

    // Next state and next frame-bit index
    always_comb begin
        nxt_state = state;
        idx_d     = idx_q;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    nxt_state = ST_START;
                    idx_d     = '0;
                end
            end
            ST_START: begin
                if (bit_end) begin
                    nxt_state = ST_DATA;
                    idx_d     = IDX_W'(1);
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    idx_d = idx_q + IDX_W'(1);
                    if (idx_q == IDX_W'(DATA_BITS)) begin
                        nxt_state = ST_STOP;
                    end
                end
            end
            ST_STOP: begin
                if (bit_end) begin
                    nxt_state = ST_IDLE;
                end
            end
        endcase
    end

    // On acceptance the live inputs set the start-bit period.
    always_comb begin
        sel_div  = accept ? rx_div    : div_q;
        sel_off  = accept ? tx_offset : off_q;
        sel_mask = accept ? corr_mask : mask_q;
        stretch  = sel_mask[idx_d];
        load     = accept || (bit_end && (nxt_state != ST_IDLE));
    end

    uart_tx_period #(.DIV_W(DIV_W)) u_period (
        .div       (sel_div),
        .offset    (sel_off),
        .stretch   (stretch),
        .period_m1 (period_m1)
    );

    uart_tx_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (period_m1),
        .expired  (expired)
    );

    // State register and per-frame capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx_q  <= '0;
            data_q <= '0;
            div_q  <= '0;
            off_q  <= 1'b0;
            mask_q <= '0;
        end else begin
            state <= nxt_state;
            idx_q <= idx_d;
            if (accept) begin
                data_q <= in_data;
                div_q  <= rx_div;
                off_q  <= tx_offset;
                mask_q <= corr_mask;
            end
        end
    end

    // Line level of the next frame bit
    always_comb begin
        dpos = idx_d - IDX_W'(1);
        unique case (nxt_state)
            ST_IDLE:  line_d = 1'b1;
            ST_START: line_d = 1'b0;
            ST_DATA:  line_d = data_q[dpos[DSEL_W-1:0]];
            ST_STOP:  line_d = 1'b1;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_line <= 1'b1;
            busy    <= 1'b0;
        end else begin
            tx_line <= line_d;
            busy    <= (nxt_state != ST_IDLE);
        end
    end
endmodule

// File: rtl/uart_tx_gen_checker.sv
module uart_tx_gen_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic tx_line,
    input logic busy
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_line);

    assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tx_line));

    assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && !tx_line));

    assert_ready_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> in_ready);
endmodule

bind uart_tx_gen uart_tx_gen_checker u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx_line  (tx_line),
    .busy     (busy)
);

// File: tb/uart_tx_gen_bench.sv
module uart_tx_gen_bench;
    localparam int DIV_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DIV_W-1:0]  rx_div = '0;
    logic              tx_offset = 1'b0;
    logic [9:0]        corr_mask = '0;
    logic              tx_line;
    logic              busy;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    uart_tx_gen #(.DIV_W(DIV_W)) u_uart_tx_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .rx_div    (rx_div),
        .tx_offset (tx_offset),
        .corr_mask (corr_mask),
        .tx_line   (tx_line),
        .busy      (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bit_len(input int div, input bit off, input logic [9:0] m, input int b);
        int eff;
        eff = (div == 0) ? 1 : div;
        return eff + int'(off) + int'(m[b]);
    endfunction

    function automatic bit bit_lvl(input logic [7:0] d, input int b);
        if (b == 0) return 1'b0;
        if (b == 9) return 1'b1;
        return d[b-1];
    endfunction

    function automatic int frame_len(input int div, input bit off, input logic [9:0] m);
        int s = 0;
        for (int b = 0; b < 10; b++) s += bit_len(div, off, m, b);
        return s;
    endfunction

    // Called at a falling edge while the block is idle; returns at the
    // falling edge right after the stop bit ends.
    task automatic run_frame(input logic [7:0] d, input int div, input bit off,
                             input logic [9:0] m, input bit scramble, input string tag);
        int miss = 0;
        int flag = 0;
        int seen = 0;
        in_data   = d;
        rx_div    = DIV_W'(div);
        tx_offset = off;
        corr_mask = m;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (scramble) begin
            in_data   = 8'($urandom);
            rx_div    = DIV_W'($urandom % 16);
            tx_offset = 1'($urandom);
            corr_mask = 10'($urandom);
        end
        for (int b = 0; b < 10; b++) begin
            for (int k = 0; k < bit_len(div, off, m, b); k++) begin
                if (tx_line !== bit_lvl(d, b)) miss++;
                if (busy !== 1'b1 || in_ready !== 1'b0) flag++;
                seen++;
                @(negedge clk);
            end
        end
        chk(miss == 0, {tag, " R2 R3 R4 R8 waveform mismatches"}, miss, 0);
        chk(flag == 0, {tag, " R6 busy high / ready low during frame"}, flag, 0);
        chk(seen == frame_len(div, off, m), {tag, " R3 frame length"}, seen,
            frame_len(div, off, m));
        chk(busy === 1'b0 && in_ready === 1'b1 && tx_line === 1'b1,
            {tag, " R7 idle cycle after stop"}, {busy, in_ready, tx_line}, 3'b011);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_line === 1'b1 && busy === 1'b0 && in_ready === 1'b1,
            "R1 reset state", {tx_line, busy, in_ready}, 3'b101);

        // Directed corner cases
        run_frame(8'hA5, 3, 1'b0, 10'h000, 1'b0, "R2 lsb-first A5");
        run_frame(8'h3C, 0, 1'b0, 10'h000, 1'b0, "R5 zero divider");
        run_frame(8'hC3, 0, 1'b1, 10'h000, 1'b0, "R5 zero divider plus offset");
        run_frame(8'h01, 1, 1'b0, 10'h3FF, 1'b0, "R4 full mask");
        run_frame(8'h80, 4, 1'b1, 10'h201, 1'b0, "R4 start and stop stretched");
        run_frame(8'h5A, 2, 1'b0, 10'h0AA, 1'b1, "R8 scramble after accept");
        // Offered immediately after the previous frame: back-to-back (R7)
        run_frame(8'hFF, 1, 1'b0, 10'h000, 1'b0, "R7 back-to-back");

        // Idle stays quiet while nothing is offered
        repeat (5) @(negedge clk);
        chk(tx_line === 1'b1 && busy === 1'b0, "R1 idle line high",
            {tx_line, busy}, 2'b10);

        for (int i = 0; i < 30; i++) begin
            int gap;
            run_frame(8'($urandom), int'($urandom % 8), 1'($urandom),
                      10'($urandom), 1'b1, "random");
            gap = int'($urandom % 3);
            for (int g = 0; g < gap; g++) @(negedge clk);
            chk(tx_line === 1'b1 && in_ready === 1'b1, "R1 idle between frames",
                {tx_line, in_ready}, 2'b11);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule